// File: doc/BRIEF.md
# Store-Multiple-Word Sequencer

This block stores a run of consecutive general registers to memory, one 32-bit word per register. A single start pulse gives it four values: the first register to store, the index and value of the base register, and a signed 16-bit displacement. The first word goes to the base plus the sign-extended displacement. A base index of zero means a base of zero, whatever base value comes with it. The block then walks upward through the register numbers to the highest register, 31 inclusive. For each register it reads the register-file port, keeps the low 32 bits of the value, and offers one write on a valid/ready memory channel. Each accepted write moves the address on by 4 bytes. The sequencer changes no status of its own. It reports only `busy` and a one-cycle `done`.

The controller is a five-state machine:
- `ST_IDLE` waits for `start`. The transition *launch* loads the address and the register index and moves to `ST_FETCH`.
- `ST_FETCH` drives the register index on the read port. It always moves on to `ST_LOAD`.
- `ST_LOAD` captures the read data, which arrives one cycle after the index. It always moves on to `ST_WRITE`.
- `ST_WRITE` holds `mem_valid` high until `mem_ready` is seen.
  - The transition *step* (an accepted write that is not the last one) returns to `ST_FETCH`.
  - The transition *finish* (an accepted write of register 31) moves to `ST_FINISH`.
- `ST_FINISH` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `multi_word_store_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `done` and `mem_valid` are all low.
- R2: The first write of an operation uses the address `base + sign_extend(disp)`, truncated to 64 bits. A displacement with bit 15 set counts as negative.
- R3: The writes cover register indices from `start_reg` upward to 31 inclusive, in that order, so there are 32 − `start_reg` writes in all. A `start_reg` of 31 gives exactly one write. During each write, `rf_idx` shows the index of the register being stored.
- R4: The data of each write is bits [31:0] of the register-file value for that index. The register file returns data one cycle after `rf_idx` is driven.
- R5: Each write after the first has the address of the previous write plus 4, wrapping modulo 2^64.
- R6: The address, the data and the index move on only in a cycle where both `mem_valid` and `mem_ready` are high. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_data` and `rf_idx` hold their values into the next cycle.
- R7: `done` is high for exactly the one cycle after the final write is accepted. `busy` is high from the cycle after launch through the `done` cycle, and low in the cycle after it.
- R8: A `start` pulse while `busy` is high has no effect. The operation in progress keeps its writes, and no further writes follow it.
- R9: When `ra_idx` is 0 the base is zero and `ra_val` is not used. For any other `ra_idx` the base is `ra_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an operation; only takes effect while idle |
| start_reg | input | 5 | First register index to store |
| ra_idx | input | 5 | Base register index; 0 selects a zero base |
| ra_val | input | 64 | Base register value |
| disp | input | 16 | Signed displacement |
| rf_idx | output | 5 | Register-file read index |
| rf_data | input | 64 | Register-file read data, one cycle after the index |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 64 | Byte address of the write |
| mem_data | output | 32 | Word to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The properties assume the following about the environment:
- The register file returns the value for the index driven in the previous cycle, and keeps returning it while that index is held.
- `mem_ready` may take any value in any cycle.
- `start` may arrive at any time; a pulse during an operation is expected to be dropped.

The stimulus stays within these assumptions in three ways:
- The bench's register-file model is a plain one-cycle registered read.
- `mem_ready` is either held high or toggled from a pseudo-random sequence.
- `start` is changed only on falling edges, and one extra pulse is deliberately placed in the middle of a transfer.

// File: rtl/mws_pkg.sv
package mws_pkg;

    // Controller states of the store sequencer
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_LOAD   = 3'd2,
        ST_WRITE  = 3'd3,
        ST_FINISH = 3'd4
    } mws_state_t;

    localparam int unsigned MWS_XLEN      = 64;
    localparam int unsigned MWS_WORD_W    = 32;
    localparam int unsigned MWS_DISP_W    = 16;
    localparam int unsigned MWS_REG_COUNT = 32;

endpackage

// File: rtl/mws_ctrl.sv
module mws_ctrl
    import mws_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       mem_ready,
    input  logic       idx_last,
    output logic       launch,
    output logic       capture,
    output logic       advance,
    output logic       mem_valid,
    output logic       busy,
    output logic       done
);

    mws_state_t state_q;
    mws_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                state_d = ST_LOAD;
            end
            ST_LOAD: begin
                state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    state_d = idx_last ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Output decode
    always_comb begin
        launch    = 1'b0;
        capture   = 1'b0;
        advance   = 1'b0;
        mem_valid = 1'b0;
        busy      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                launch = start;
            end
            ST_FETCH: begin
                busy = 1'b1;
            end
            ST_LOAD: begin
                busy    = 1'b1;
                capture = 1'b1;
            end
            ST_WRITE: begin
                busy      = 1'b1;
                mem_valid = 1'b1;
                advance   = mem_ready;
            end
            ST_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mws_addr_gen.sv
module mws_addr_gen #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned DISP_W = 16,
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              advance,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [DISP_W-1:0] disp,
    output logic [XLEN-1:0]   addr
);

    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] disp_ext;

    // Base register index zero stands for a literal zero base
    assign base = (ra_idx == '0) ? '0 : ra_val;

    generate
        if (DISP_W < XLEN) begin : g_sext
            assign disp_ext = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            assign disp_ext = disp[XLEN-1:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (launch) begin
            addr <= base + disp_ext;
        end else if (advance) begin
            addr <= addr + STEP_V;
        end
    end

endmodule

// File: rtl/mws_idx_ctr.sv
module mws_idx_ctr #(
    parameter int unsigned REG_COUNT = 32,
    parameter int unsigned IDX_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             advance,
    input  logic [IDX_W-1:0] start_reg,
    output logic [IDX_W-1:0] idx,
    output logic             idx_last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REG_COUNT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (launch) begin
            idx <= start_reg;
        end else if (advance) begin
            idx <= idx + 1'b1;
        end
    end

    assign idx_last = (idx == LAST_IDX);

endmodule

// File: rtl/mws_word_hold.sv
module mws_word_hold #(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [XLEN-1:0]   rf_data,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] low_word;

    generate
        if (WORD_W < XLEN) begin : g_slice
            assign low_word = rf_data[WORD_W-1:0];
        end else begin : g_zext
            assign low_word = WORD_W'(rf_data);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (capture) begin
            word <= low_word;
        end
    end

endmodule

// File: rtl/multi_word_store_seq.sv
module multi_word_store_seq
    import mws_pkg::*;
#(
    parameter int unsigned XLEN      = MWS_XLEN,
    parameter int unsigned WORD_W    = MWS_WORD_W,
    parameter int unsigned DISP_W    = MWS_DISP_W,
    parameter int unsigned REG_COUNT = MWS_REG_COUNT,
    localparam int unsigned IDX_W    = $clog2(REG_COUNT),
    localparam int unsigned STEP     = WORD_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_reg,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [DISP_W-1:0] disp,
    output logic [IDX_W-1:0]  rf_idx,
    input  logic [XLEN-1:0]   rf_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [XLEN-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_data,
    output logic              busy,
    output logic              done
);

    logic launch;
    logic capture;
    logic advance;
    logic idx_last;

    mws_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_ready (mem_ready),
        .idx_last  (idx_last),
        .launch    (launch),
        .capture   (capture),
        .advance   (advance),
        .mem_valid (mem_valid),
        .busy      (busy),
        .done      (done)
    );

    mws_addr_gen #(
        .XLEN   (XLEN),
        .DISP_W (DISP_W),
        .IDX_W  (IDX_W),
        .STEP   (STEP)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .advance (advance),
        .ra_idx  (ra_idx),
        .ra_val  (ra_val),
        .disp    (disp),
        .addr    (mem_addr)
    );

    mws_idx_ctr #(
        .REG_COUNT (REG_COUNT),
        .IDX_W     (IDX_W)
    ) u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .advance   (advance),
        .start_reg (start_reg),
        .idx       (rf_idx),
        .idx_last  (idx_last)
    );

    mws_word_hold #(
        .XLEN   (XLEN),
        .WORD_W (WORD_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .rf_data (rf_data),
        .word    (mem_data)
    );

endmodule

// File: rtl/mws_checker.sv
module mws_checker #(
    parameter int unsigned XLEN      = 64,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned REG_COUNT = 32,
    parameter int unsigned IDX_W     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [IDX_W-1:0]  rf_idx,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [XLEN-1:0]   mem_addr,
    input logic [WORD_W-1:0] mem_data,
    input logic              busy,
    input logic              done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REG_COUNT - 1);
    localparam logic [XLEN-1:0]  STEP_V   = XLEN'(WORD_W / 8);

    logic accept;
    assign accept = mem_valid && mem_ready;

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_data) && $stable(rf_idx));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (rf_idx != LAST_IDX) |=> mem_addr == $past(mem_addr) + STEP_V);

    p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (rf_idx != LAST_IDX) |=> rf_idx == $past(rf_idx) + 1'b1);

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (rf_idx == LAST_IDX) |=> done && !mem_valid);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_no_done_midway_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (rf_idx != LAST_IDX) |=> !done && busy);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid && !done);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && start |=> busy);

endmodule

bind multi_word_store_seq mws_checker #(
    .XLEN      (XLEN),
    .WORD_W    (WORD_W),
    .REG_COUNT (REG_COUNT),
    .IDX_W     (IDX_W)
) u_mws_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rf_idx    (rf_idx),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .busy      (busy),
    .done      (done)
);

// File: tb/test_multi_word_store_seq.sv
module test_multi_word_store_seq;

    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic [4:0]  idx;
        logic [63:0] addr;
        logic [31:0] data;
        logic        first;
        logic        last;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  start_reg = '0;
    logic [4:0]  ra_idx = '0;
    logic [63:0] ra_val = '0;
    logic [15:0] disp = '0;
    logic [4:0]  rf_idx;
    logic [63:0] rf_data = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [63:0] mem_addr;
    logic [31:0] mem_data;
    logic        busy;
    logic        done;

    int checks = 0;
    int bad = 0;
    int writes_seen = 0;
    bit finished = 0;
    bit rand_ready = 0;
    bit pend_done = 0;
    bit stall_prev = 0;
    logic [63:0] prev_addr;
    logic [31:0] prev_data;
    logic [4:0]  prev_idx;
    logic [15:0] lfsr = 16'hACE1;
    logic [63:0] regs [32];
    exp_t exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    multi_word_store_seq i_multi_word_store_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_reg (start_reg),
        .ra_idx    (ra_idx),
        .ra_val    (ra_val),
        .disp      (disp),
        .rf_idx    (rf_idx),
        .rf_data   (rf_data),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .busy      (busy),
        .done      (done)
    );

    // Register file model: one cycle read latency
    always @(posedge clk) rf_data <= regs[rf_idx];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_ready = rand_ready ? (lfsr[0] | lfsr[5]) : 1'b1;
            if (pend_done) begin
                check(done === 1'b1, "R7", "done after final write", 64'(done), 64'd1);
                pend_done = 0;
            end
            if (stall_prev) begin
                check(mem_valid === 1'b1 && mem_addr === prev_addr && mem_data === prev_data
                      && rf_idx === prev_idx, "R6", "hold while stalled", mem_addr, prev_addr);
            end
            stall_prev = 0;
            if (mem_valid) begin
                prev_addr = mem_addr;
                prev_data = mem_data;
                prev_idx  = rf_idx;
                stall_prev = !mem_ready;
                if (mem_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected write", mem_addr, 64'd0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(rf_idx === e.idx, "R3", "register index", 64'(rf_idx), 64'(e.idx));
                        check(mem_addr === e.addr, e.first ? "R2" : "R5", "address",
                              mem_addr, e.addr);
                        check(mem_data === e.data, "R4", "data", 64'(mem_data), 64'(e.data));
                        writes_seen++;
                        if (e.last) pend_done = 1;
                    end
                end
            end
        end
    end

    task automatic run_op(input logic [4:0] sr, input logic [4:0] rai, input logic [63:0] rav,
                          input logic [15:0] d, input bit poke_mid);
        logic [63:0] ea;
        ea = ((rai == 5'd0) ? 64'd0 : rav) + {{48{d[15]}}, d};
        for (int r = sr; r < 32; r++) begin
            exp_t e;
            e.idx   = 5'(r);
            e.addr  = ea;
            e.data  = regs[r][31:0];
            e.first = (r == sr);
            e.last  = (r == 31);
            exp_q.push_back(e);
            ea = ea + 64'd4;
        end
        writes_seen = 0;
        @(negedge clk);
        start = 1'b1; start_reg = sr; ra_idx = rai; ra_val = rav; disp = d;
        @(negedge clk);
        start = 1'b0; ra_val = 64'hDEAD_BEEF_0BAD_F00D; disp = 16'h7777;
        check(busy === 1'b1, "R7", "busy after launch", 64'(busy), 64'd1);
        if (poke_mid) begin
            repeat (4) @(negedge clk);
            start = 1'b1; start_reg = 5'd2; ra_idx = 5'd1; ra_val = 64'h5000;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        check(writes_seen == 32 - int'(sr), "R3", "write count", 64'(writes_seen),
              64'(32 - int'(sr)));
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R7", "busy/done drop", 64'({busy, done}), 64'd0);
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0 && mem_valid === 1'b0, "R8", "quiet after op",
              64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            regs[i] = {32'hF00D_0000 + 32'(i), 32'hC0DE_0000 + 32'(i) * 32'h0101_0101};
        end
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && mem_valid === 1'b0, "R1", "in reset",
              64'({busy, done, mem_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && mem_valid === 1'b0, "R1", "after reset",
              64'({busy, done, mem_valid}), 64'd0);

        // R9: zero base index ignores ra_val
        run_op(5'd28, 5'd0, 64'h1234_5678_9ABC_DEF0, 16'h0100, 0);
        // R3: single write from register 31
        run_op(5'd31, 5'd5, 64'h1000, 16'hFFFC, 0);
        // R2 negative displacement, R6 random stalls
        rand_ready = 1;
        run_op(5'd20, 5'd3, 64'h2000_0000_0000_0010, 16'h8000, 0);
        // R8: start pulse while busy
        run_op(5'd26, 5'd7, 64'h0000_0000_0040_0000, 16'h0010, 1);
        // R5: address wrap
        for (int i = 0; i < 32; i++) regs[i] = ~regs[i];
        run_op(5'd29, 5'd9, 64'hFFFF_FFFF_FFFF_FFF8, 16'h0000, 0);
        // Full run from register 0
        rand_ready = 0;
        run_op(5'd0, 5'd31, 64'h0000_0000_8000_0000, 16'h7FFC, 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule